// File: doc/BRIEF.md
# Serial Bus Pause Gate

This block sits between the sampled pins of a serial memory slave and its command engine. It can freeze a transfer in the middle of a command and resume it later without aborting it. All pins are sampled in the system clock domain. The block watches the select line, the serial clock and an active-low pause request. From these it produces two gated shift strobes: one for the bit-capture (rising) edge and one for the bit-launch (falling) edge. It also produces a pause status flag, a forced-high-impedance request for the serial data output, and an abort pulse.

A pause is taken only while the device is selected. When the pause begins, the block records the level of the serial clock. The pause ends only when the request is withdrawn while the serial clock is back at that recorded level. Between those points, no shift strobe reaches the command engine, so the engine's bit counter and state stay where they were. Clock and data activity during the pause are ignored. The serial clock history keeps being tracked, so no edge is counted twice on release.

If the select line is released during a pause, the block raises an abort pulse. If the command engine had not yet recognised the opcode at that moment, the block also raises a second pulse. That pulse tells the engine to keep its write-enable latch at the value it had before the pause.

Top module: `spi_pause_gate`

## Requirements
- R1: After reset, `paused`, `so_hiz`, `abort`, `keep_wel` and both shift strobes are 0.
- R2: While `sel_n` is 1, a low `pause_n` has no effect. `paused` stays 0, and serial clock edges produce no shift strobe.
- R3: While `sel_n` is 0 and no pause is active, a sampled `pause_n` of 0 sets `paused` to 1 from the next clock. The sampled level of `bclk` in that cycle is recorded.
- R4: Consider a pause entered with `bclk` at 0. It is released (`paused` at 0 from the next clock) only in a cycle that samples `pause_n` at 1 and `bclk` at 0. Raising `pause_n` while `bclk` is 1 leaves it paused.
- R5: Consider a pause entered with `bclk` at 1. It is released only in a cycle that samples `pause_n` at 1 and `bclk` at 1. Raising `pause_n` while `bclk` is 0 leaves it paused.
- R6: `shift_in_en` pulses in the cycle where sampled `bclk` goes from 0 to 1, and `shift_out_en` pulses where it goes from 1 to 0. Both strobes need the block to be selected, not paused and with `pause_n` at 1. A byte sent MSB first with one pause inserted at any bit therefore gives exactly 8 capture strobes and 7 launch strobes, and the captured byte equals the sent byte.
- R7: `so_hiz` is 1 exactly while `paused` is 1 and `rd_cmd` is 1.
- R8: `abort` is 1 in a cycle where `paused` is 1 and `sel_n` is sampled at 1, and `paused` is 0 from the next clock. Releasing the select line with no pause active gives no `abort`.
- R9: `keep_wel` is 1 only together with `abort`, and only when `opc_seen` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Sampled select line, active low |
| bclk | input | 1 | Sampled serial clock level |
| pause_n | input | 1 | Sampled pause request, active low |
| rd_cmd | input | 1 | Command engine is executing a read-type command |
| opc_seen | input | 1 | Command engine has recognised the opcode |
| shift_in_en | output | 1 | Gated strobe for the capture edge |
| shift_out_en | output | 1 | Gated strobe for the launch edge |
| paused | output | 1 | A pause is active |
| so_hiz | output | 1 | Force the serial data output to high impedance |
| abort | output | 1 | Select released during a pause; abort the command |
| keep_wel | output | 1 | Abort before opcode recognition; keep the write-enable latch |

## Verification
The assertions check on every cycle these behaviours:
- no strobe ever appears while paused;
- a deselect always clears the pause;
- a pause is taken whenever one is requested while selected;
- a pause never releases while the pin level disagrees with the recorded clock phase;
- the high-impedance request tracks the pause for read commands;
- the abort and keep-latch pulses appear only in their qualifying cycles.

Only the bench's sweeps can show the end-to-end property. For each entry phase and each bit position, a byte interrupted by a pause, with clock and data noise injected during it, arrives intact. The sweeps also confirm the exact number of capture and launch strobes, so no edge is lost or duplicated around the release.

// File: rtl/pause_gate_pkg.sv
package pause_gate_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_PAUSE_LO = 2'd1,
    ST_PAUSE_HI = 2'd2
  } pause_st_t;

  // Pause state to enter, given the clock level seen when the request arrives.
  function automatic pause_st_t entry_state(input logic clk_lvl);
    return clk_lvl ? ST_PAUSE_HI : ST_PAUSE_LO;
  endfunction

  // Level of the serial clock that the release must match.
  function automatic logic phase_lvl(input pause_st_t st);
    return (st == ST_PAUSE_HI);
  endfunction

  // Release allowed: request withdrawn and clock back at the entry phase.
  function automatic logic release_ok(input pause_st_t st, input logic req_n,
                                      input logic clk_lvl);
    return req_n && (phase_lvl(st) == clk_lvl);
  endfunction

endpackage

// File: rtl/pg_edge_det.sv
module pg_edge_det #(
  parameter bit IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  // Tracks the pin at all times, paused or not, so no edge is replayed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= IDLE_LVL;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/pg_pause_fsm.sv
module pg_pause_fsm
  import pause_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_n,
  input  logic      bclk,
  input  logic      pause_n,
  output pause_st_t st_o,
  output logic      paused,
  output logic      release_now,
  output logic      cut
);
  pause_st_t st_q, st_d;

  assign paused      = (st_q != ST_RUN);
  assign release_now = paused && !sel_n && release_ok(st_q, pause_n, bclk);
  assign cut         = paused && sel_n;

  always_comb begin
    st_d = st_q;
    if (sel_n)                 st_d = ST_RUN;
    else if (!paused) begin
      if (!pause_n)            st_d = entry_state(bclk);
    end
    else if (release_now)      st_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/pg_out_gate.sv
module pg_out_gate (
  input  logic sel_n,
  input  logic pause_n,
  input  logic paused,
  input  logic clk_rise,
  input  logic clk_fall,
  input  logic rd_cmd,
  input  logic cut,
  input  logic opc_seen,
  output logic shift_in_en,
  output logic shift_out_en,
  output logic so_hiz,
  output logic abort,
  output logic keep_wel
);
  logic pass;

  assign pass         = !sel_n && !paused && pause_n;
  assign shift_in_en  = pass && clk_rise;
  assign shift_out_en = pass && clk_fall;
  assign so_hiz       = paused && rd_cmd;
  assign abort        = cut;
  assign keep_wel     = cut && !opc_seen;
endmodule

// File: rtl/spi_pause_gate.sv
module spi_pause_gate
  import pause_gate_pkg::*;
#(
  parameter bit BCLK_IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic bclk,
  input  logic pause_n,
  input  logic rd_cmd,
  input  logic opc_seen,
  output logic shift_in_en,
  output logic shift_out_en,
  output logic paused,
  output logic so_hiz,
  output logic abort,
  output logic keep_wel
);
  logic      bclk_rise, bclk_fall;
  logic      release_now, cut;
  pause_st_t pause_st;
  logic      pause_lvl;

  pg_edge_det #(.IDLE_LVL(BCLK_IDLE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(bclk), .rise(bclk_rise), .fall(bclk_fall)
  );

  pg_pause_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bclk(bclk), .pause_n(pause_n),
    .st_o(pause_st), .paused(paused), .release_now(release_now), .cut(cut)
  );

  assign pause_lvl = phase_lvl(pause_st);

  pg_out_gate u_gate (
    .sel_n(sel_n), .pause_n(pause_n), .paused(paused),
    .clk_rise(bclk_rise), .clk_fall(bclk_fall), .rd_cmd(rd_cmd), .cut(cut),
    .opc_seen(opc_seen), .shift_in_en(shift_in_en), .shift_out_en(shift_out_en),
    .so_hiz(so_hiz), .abort(abort), .keep_wel(keep_wel)
  );
endmodule

// File: rtl/pg_checker.sv
module pg_checker (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic bclk,
  input logic pause_n,
  input logic rd_cmd,
  input logic opc_seen,
  input logic shift_in_en,
  input logic shift_out_en,
  input logic paused,
  input logic so_hiz,
  input logic abort,
  input logic keep_wel,
  input logic pause_lvl
);
  a_r2_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !paused);
  a_r2_no_strobe_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !shift_in_en && !shift_out_en);
  a_r3_enter: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n && !pause_n && !paused |=> paused && (pause_lvl == $past(bclk)));
  a_r4_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    paused && !sel_n && !(pause_n && (bclk == pause_lvl)) |=> paused);
  a_r6_no_strobe_paused: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !shift_in_en && !shift_out_en);
  a_r7_hiz_on: assert property (@(posedge clk) disable iff (!rst_n)
    paused && rd_cmd |-> so_hiz);
  a_r7_hiz_off: assert property (@(posedge clk) disable iff (!rst_n)
    !paused |-> !so_hiz);
  a_r8_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> sel_n && paused);
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !paused && !abort);
  a_r9_keep_wel: assert property (@(posedge clk) disable iff (!rst_n)
    keep_wel |-> abort && !opc_seen);
endmodule

bind spi_pause_gate pg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bclk(bclk), .pause_n(pause_n),
  .rd_cmd(rd_cmd), .opc_seen(opc_seen), .shift_in_en(shift_in_en),
  .shift_out_en(shift_out_en), .paused(paused), .so_hiz(so_hiz),
  .abort(abort), .keep_wel(keep_wel), .pause_lvl(pause_lvl)
);

// File: tb/test_spi_pause_gate.sv
`timescale 1ns/100ps
module test_spi_pause_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, bclk = 1'b0, pause_n = 1'b1, rd_cmd = 1'b0, opc_seen = 1'b0;
  logic din = 1'b0;
  logic shift_in_en, shift_out_en, paused, so_hiz, abort, keep_wel;

  int   n_cmp = 0, n_bad = 0;
  int   nrise = 0, nfall = 0;
  logic [7:0] rx = 8'd0;
  logic m_abort = 1'b0, m_keep = 1'b0;

  always #2.5 clk = ~clk;

  spi_pause_gate i_spi_pause_gate (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bclk(bclk), .pause_n(pause_n),
    .rd_cmd(rd_cmd), .opc_seen(opc_seen), .shift_in_en(shift_in_en),
    .shift_out_en(shift_out_en), .paused(paused), .so_hiz(so_hiz),
    .abort(abort), .keep_wel(keep_wel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle: inputs at negedge, strobes sampled mid-cycle,
  // return just after the following posedge so registered state is visible.
  task automatic drv(input logic s, input logic b, input logic d, input logic p);
    @(negedge clk);
    sel_n = s; bclk = b; din = d; pause_n = p;
    #1;
    if (shift_in_en) begin rx = {rx[6:0], din}; nrise++; end
    if (shift_out_en) nfall++;
    m_abort = abort;
    m_keep  = keep_wel;
    @(posedge clk); #1;
  endtask

  initial begin
    #900000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rd_cmd = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 paused", paused, 0);
    chk("R1 so_hiz", so_hiz, 0);
    chk("R1 strobes", shift_in_en | shift_out_en | abort | keep_wel, 0);
    rst_n = 1'b1;
    drv(1, 0, 0, 1);
    chk("R1 paused after release", paused, 0);

    // R2: pause request and clock activity while deselected
    nrise = 0; nfall = 0;
    drv(1, 0, 0, 0); drv(1, 1, 1, 0); drv(1, 0, 0, 0); drv(1, 1, 1, 0);
    chk("R2 paused while deselected", paused, 0);
    chk("R2 capture strobes", nrise, 0);
    chk("R2 launch strobes", nfall, 0);
    drv(1, 0, 0, 1);

    // R3..R7 sweep: entry phase x bit position
    for (int lvl = 0; lvl < 2; lvl++) begin
      for (int p = 0; p < 8; p++) begin
        logic [7:0] data;
        data   = 8'h5A ^ 8'(p * 29) ^ (lvl == 1 ? 8'hC3 : 8'h00);
        rd_cmd = (lvl == 0);
        drv(1, 0, 0, 1);
        rx = 8'd0; nrise = 0; nfall = 0;
        drv(0, 0, 0, 1);
        for (int b = 0; b < 8; b++) begin
          logic bt;
          bt = data[7 - b];
          drv(0, 0, bt, 1);
          if (lvl == 0 && b == p) begin
            drv(0, 0, bt, 0);
            chk("R3 enter low phase", paused, 1);
            chk("R7 hiz during read pause", so_hiz, 1);
            drv(0, 1, ~bt, 0); drv(0, 0, ~bt, 0); drv(0, 1, ~bt, 0);
            drv(0, 1, ~bt, 1);
            chk("R4 release at wrong phase", paused, 1);
            drv(0, 0, bt, 1);
            chk("R4 release at low phase", paused, 0);
            chk("R7 hiz after release", so_hiz, 0);
          end
          drv(0, 1, bt, 1);
          if (lvl == 1 && b == p) begin
            drv(0, 1, bt, 0);
            chk("R3 enter high phase", paused, 1);
            chk("R7 no hiz for non-read", so_hiz, 0);
            drv(0, 0, ~bt, 0); drv(0, 1, ~bt, 0); drv(0, 0, ~bt, 0);
            drv(0, 0, ~bt, 1);
            chk("R5 release at wrong phase", paused, 1);
            drv(0, 1, bt, 1);
            chk("R5 release at high phase", paused, 0);
          end
        end
        chk("R6 byte intact", int'(rx), int'(data));
        chk("R6 capture strobes", nrise, 8);
        chk("R6 launch strobes", nfall, 7);
        drv(1, 0, 0, 1);
      end
    end

    // R8/R9: select released during a pause
    rd_cmd = 1'b0;
    for (int o = 0; o < 2; o++) begin
      opc_seen = o[0];
      drv(0, 0, 0, 1);
      drv(0, 0, 0, 0);
      chk("R8 paused before deselect", paused, 1);
      drv(1, 0, 0, 0);
      chk("R8 abort pulse", m_abort, 1);
      chk("R9 keep_wel", m_keep, o == 0 ? 1 : 0);
      chk("R8 pause cleared", paused, 0);
      drv(1, 0, 0, 1);
      chk("R8 abort one cycle", m_abort, 0);
    end
    opc_seen = 1'b0;
    drv(0, 0, 0, 1);
    drv(1, 0, 0, 1);
    chk("R8 no abort without pause", m_abort, 0);
    chk("R9 no keep without pause", m_keep, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule